// File: doc/BRIEF.md
# DRAM Refresh and Initialization Scheduler

This block decides when an asynchronous, multiplexed-address DRAM must be refreshed. It runs on the controller clock and measures every time window by counting cycles against parameters. After reset it holds off all activity for a start-up window. It then asks for a fixed number of dummy refresh cycles. Once those are done it raises a ready flag, and from then on it generates one refresh request per refresh interval.

The memory access sequencer carries out the refreshes. It sees a request line and accepts one refresh by raising the acknowledge in a cycle where the request is high. The sequencer may put refreshes off. The block records each owed refresh in a saturating backlog counter, and it raises an urgent flag when that backlog is full. A mode input chooses between two refresh styles:

- **Row-addressed refresh:** the block supplies the row address from its own counter.
- **Self-addressed refresh:** the device steps its internal row counter, and the block's row counter holds.

The block never drives the DRAM pins.

Top module: `dram_refresh_sched`

## Requirements
- R1: After reset is released, `ref_req_o` and `ready_o` stay low for STARTUP_CYC clock edges. `ref_req_o` rises after edge number STARTUP_CYC.
- R2: During initialization, `ref_req_o` stays high until INIT_REFRESHES refreshes have been accepted. A refresh is accepted when `ref_req_o` and `ref_ack_i` are both high at a clock edge. `ready_o` rises at the edge that accepts the last of these refreshes, and it stays high until reset.
- R3: Once `ready_o` is high, the owed count rises by one every REFRESH_INTERVAL clock edges. The first increment happens REFRESH_INTERVAL edges after `ready_o` rises.
- R4: Once `ready_o` is high, `ref_req_o` is high exactly when `owed_o` is non-zero. Each accepted refresh lowers `owed_o` by one. An accepted refresh at the same edge as an interval increment leaves `owed_o` unchanged.
- R5: `owed_o` saturates at MAX_OWED, and increments that arrive at saturation are dropped. `urgent_o` is high exactly when `owed_o` equals MAX_OWED.
- R6: When `mode_row_i` = 1 (row-addressed refresh), each accepted refresh advances `ref_row_o` by one. `ref_row_o` always shows the row for the next refresh, and it wraps from 2^ROW_W-1 (4095 for 12 bits) to 0.
- R7: When `mode_row_i` = 0 (self-addressed refresh), accepted refreshes leave `ref_row_o` unchanged.
- R8: `ref_ack_i` is ignored while `ref_req_o` is low: it changes neither `owed_o`, `ref_row_o` nor the initialization progress.
- R9: While `rst_ni` is low, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| mode_row_i | input | 1 | 1 = row-addressed refresh, 0 = self-addressed refresh |
| ref_ack_i | input | 1 | Sequencer accepts the pending refresh |
| ref_req_o | output | 1 | Refresh requested |
| ref_row_o | output | ROW_W | Row for the next row-addressed refresh |
| ready_o | output | 1 | Initialization complete; normal accesses allowed |
| urgent_o | output | 1 | Backlog full; refresh must take priority |
| owed_o | output | $clog2(MAX_OWED+1) | Number of refreshes owed |

## Verification
The bench counts edges after reset and after ready, so the start-up and interval boundaries are checked one cycle before and at the edge where they take effect. This catches off-by-one errors in either timer.

The initialization phase is driven with bursts of acknowledges separated by idle gaps. This separates counting of accepted refreshes from a count based on elapsed time.

In the running phase the backlog is filled to saturation and then drained. One acknowledge is placed on the exact edge of an interval increment to expose a wrong priority between increment and decrement. Acknowledges with no pending request are also sent.

A second instance with a long initialization count takes 4096 back-to-back acknowledges. It shows the row counter wrapping from 4095 to 0, and the bench checks that the counter holds in self-addressed mode.

// File: rtl/dram_refresh_pkg.sv
package dram_refresh_pkg;
  typedef enum logic [1:0] {
    PH_STARTUP = 2'd0,
    PH_INIT    = 2'd1,
    PH_RUN     = 2'd2
  } phase_e;
endpackage

// File: rtl/refresh_cycle_timer.sv
module refresh_cycle_timer #(
  parameter int unsigned PERIOD = 1562
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int unsigned CW = $clog2(PERIOD + 1);
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (!en_i || tick_o)   cnt_q <= '0;
    else                        cnt_q <= cnt_q + 1'b1;
  end

  // R3: count never passes the period end
  a_r3_count_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  // R3: disabling restarts the window
  a_r3_restart_on_disable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> cnt_q == '0);
endmodule

// File: rtl/refresh_owed_counter.sv
module refresh_owed_counter #(
  parameter int unsigned MAX_OWED = 8,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          take_i,
  output logic [OW-1:0] owed_o,
  output logic          full_o
);
  localparam logic [OW:0] MAXV = (OW+1)'(MAX_OWED);

  logic [OW-1:0] owed_q;
  logic [OW:0]   sum;
  logic          dec;

  assign dec = take_i && (owed_q != '0);

  always_comb begin
    sum = {1'b0, owed_q} + (OW+1)'(tick_i) - (OW+1)'(dec);
    if (sum > MAXV) sum = MAXV;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) owed_q <= '0;
    else         owed_q <= sum[OW-1:0];
  end

  assign owed_o = owed_q;
  assign full_o = ({1'b0, owed_q} == MAXV);

  a_r5_never_above_max: assert property (@(posedge clk_i) disable iff (!rst_ni)
    {1'b0, owed_q} <= MAXV);
  a_r4_take_decrements: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_i && !tick_i && owed_q != '0) |=> owed_q == $past(owed_q) - 1'b1);
  a_r5_full_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && !take_i) |=> full_o);
endmodule

// File: rtl/refresh_row_counter.sv
module refresh_row_counter #(
  parameter int unsigned ROW_W = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  output logic [ROW_W-1:0] row_o
);
  logic [ROW_W-1:0] row_q;

  // natural wrap at 2^ROW_W
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     row_q <= '0;
    else if (step_i) row_q <= row_q + 1'b1;
  end

  assign row_o = row_q;

  a_r6_row_advance: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |=> row_q == $past(row_q) + 1'b1);
  a_r7_row_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(row_q));
endmodule

// File: rtl/dram_refresh_sched.sv
module dram_refresh_sched
  import dram_refresh_pkg::*;
#(
  parameter int unsigned STARTUP_CYC      = 20000,
  parameter int unsigned INIT_REFRESHES   = 8,
  parameter int unsigned REFRESH_INTERVAL = 1562,
  parameter int unsigned MAX_OWED         = 8,
  parameter int unsigned ROW_W            = 12,
  localparam int unsigned OW = $clog2(MAX_OWED + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             mode_row_i,
  input  logic             ref_ack_i,
  output logic             ref_req_o,
  output logic [ROW_W-1:0] ref_row_o,
  output logic             ready_o,
  output logic             urgent_o,
  output logic [OW-1:0]    owed_o
);
  localparam int unsigned IW = $clog2(INIT_REFRESHES + 1);
  localparam logic [IW-1:0] INIT_LAST = IW'(INIT_REFRESHES - 1);

  phase_e        phase_q;
  logic [IW-1:0] init_cnt_q;
  logic          start_tick, intv_tick, accept, full;
  logic [OW-1:0] owed;

  refresh_cycle_timer #(.PERIOD(STARTUP_CYC)) u_start_timer (
    .clk_i, .rst_ni, .en_i(phase_q == PH_STARTUP), .tick_o(start_tick));

  refresh_cycle_timer #(.PERIOD(REFRESH_INTERVAL)) u_intv_timer (
    .clk_i, .rst_ni, .en_i(phase_q == PH_RUN), .tick_o(intv_tick));

  assign ref_req_o = (phase_q == PH_INIT) || ((phase_q == PH_RUN) && (owed != '0));
  assign accept    = ref_req_o && ref_ack_i;

  refresh_owed_counter #(.MAX_OWED(MAX_OWED)) u_owed (
    .clk_i, .rst_ni, .tick_i(intv_tick), .take_i(accept && (phase_q == PH_RUN)),
    .owed_o(owed), .full_o(full));

  refresh_row_counter #(.ROW_W(ROW_W)) u_row (
    .clk_i, .rst_ni, .step_i(accept && mode_row_i), .row_o(ref_row_o));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q    <= PH_STARTUP;
      init_cnt_q <= '0;
    end else begin
      unique case (phase_q)
        PH_STARTUP: if (start_tick) phase_q <= PH_INIT;
        PH_INIT: if (accept) begin
          init_cnt_q <= init_cnt_q + 1'b1;
          if (init_cnt_q == INIT_LAST) phase_q <= PH_RUN;
        end
        default: ;
      endcase
    end
  end

  assign ready_o  = (phase_q == PH_RUN);
  assign urgent_o = full;
  assign owed_o   = owed;

  a_r2_ready_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o |=> ready_o);
  a_r2_req_held_in_init: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_INIT && !(accept && init_cnt_q == INIT_LAST)) |=> ref_req_o);
  a_r8_no_accept_no_progress: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(init_cnt_q));
  a_r1_no_ready_in_startup: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_q == PH_STARTUP) |-> (!ready_o && !ref_req_o));
endmodule

// File: tb/dram_refresh_sched_tb.sv
`timescale 1ns/1ps
module dram_refresh_sched_tb;
  localparam int STARTUP = 50;
  localparam int INITN   = 8;
  localparam int INTV    = 20;
  localparam int MAXO    = 3;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic mode = 1'b1, ack = 1'b0, ack_w = 1'b0;
  logic req, ready, urgent, req_w, ready_w, urgent_w;
  logic [11:0] row, row_w;
  logic [1:0] owed, owed_w;

  int checks = 0, errors = 0, steps = 0, ready_at = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dram_refresh_sched #(.STARTUP_CYC(STARTUP), .INIT_REFRESHES(INITN),
    .REFRESH_INTERVAL(INTV), .MAX_OWED(MAXO), .ROW_W(12)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_row_i(mode), .ref_ack_i(ack),
    .ref_req_o(req), .ref_row_o(row), .ready_o(ready), .urgent_o(urgent), .owed_o(owed));

  dram_refresh_sched #(.STARTUP_CYC(4), .INIT_REFRESHES(4100),
    .REFRESH_INTERVAL(INTV), .MAX_OWED(MAXO), .ROW_W(12)) u_dut_wrap (
    .clk_i(clk), .rst_ni(rst_ni), .mode_row_i(1'b1), .ref_ack_i(ack_w),
    .ref_req_o(req_w), .ref_row_o(row_w), .ready_o(ready_w), .urgent_o(urgent_w), .owed_o(owed_w));

  task automatic step();
    @(posedge clk); #2;
    steps++;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic advance_to(input int off);
    while ((steps - ready_at) < off) step();
  endtask

  task automatic t_reset();
    #23;
    chk("R9 req", req, 0); chk("R9 ready", ready, 0);
    chk("R9 urgent", urgent, 0); chk("R9 owed", owed, 0); chk("R9 row", row, 0);
    @(posedge clk); #2; rst_ni = 1'b1;
  endtask

  task automatic t_startup();
    repeat (STARTUP - 1) step();
    chk("R1 req before window end", req, 0);
    chk("R1 ready before window end", ready, 0);
    step();
    chk("R1 req at window end", req, 1);
    chk("R1 ready at window end", ready, 0);
  endtask

  task automatic t_init();
    for (int i = 1; i < INITN; i++) begin
      ack = 1'b1; step();
      chk("R6 init row", row, i);
      chk("R2 not ready", ready, 0);
    end
    ack = 1'b0;
    repeat (5) step();
    chk("R2 req held", req, 1);
    chk("R8 row idle", row, INITN - 1);
    chk("R2 still not ready", ready, 0);
    ack = 1'b1; step(); ack = 1'b0;
    ready_at = steps;
    chk("R2 ready", ready, 1);
    chk("R4 req low no owed", req, 0);
    chk("R6 row after init", row, INITN);
  endtask

  task automatic t_interval();
    ack = 1'b1; step(); ack = 1'b0;
    chk("R8 ack ignored owed", owed, 0);
    chk("R8 ack ignored row", row, INITN);
    advance_to(INTV - 1);
    chk("R3 owed before interval", owed, 0);
    chk("R3 req before interval", req, 0);
    step();
    chk("R3 owed after interval", owed, 1);
    chk("R4 req with owed", req, 1);
  endtask

  task automatic t_saturate();
    advance_to(2 * INTV);
    chk("R3 owed two", owed, 2); chk("R5 not urgent", urgent, 0);
    advance_to(3 * INTV);
    chk("R5 owed max", owed, MAXO); chk("R5 urgent", urgent, 1);
    advance_to(4 * INTV);
    chk("R5 saturated", owed, MAXO); chk("R5 still urgent", urgent, 1);
  endtask

  task automatic t_self_addressed();
    mode = 1'b0;
    ack = 1'b1; step(); ack = 1'b0;
    chk("R4 decrement", owed, 2);
    chk("R5 urgent cleared", urgent, 0);
    chk("R7 row held", row, INITN);
  endtask

  task automatic t_collide();
    mode = 1'b1;
    advance_to(5 * INTV - 1);
    chk("R4 owed pre collide", owed, 2);
    ack = 1'b1; step(); ack = 1'b0;
    chk("R4 tick plus accept", owed, 2);
    chk("R6 row step", row, INITN + 1);
    ack = 1'b1; step(); step(); ack = 1'b0;
    chk("R4 drained", owed, 0);
    chk("R4 req low drained", req, 0);
    chk("R6 row after drain", row, INITN + 3);
  endtask

  task automatic t_wrap();
    chk("R1 wrap inst req", req_w, 1);
    ack_w = 1'b1;
    repeat (4095) step();
    chk("R6 row at top", row_w, 4095);
    step(); ack_w = 1'b0;
    chk("R6 row wrapped", row_w, 0);
    chk("R2 wrap inst not ready", ready_w, 0);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    t_reset();
    t_startup();
    t_init();
    t_interval();
    t_saturate();
    t_self_addressed();
    t_collide();
    t_wrap();
    finish_run();
  end

  initial begin
    #(200000 * 10);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule